// File: doc/BRIEF.md
# Register Rename Map with Free List

This block holds the speculative mapping from architectural register numbers to physical register numbers in an out-of-order core. The rename stage reads two source operands per cycle through two lookup ports. Each lookup returns the physical register currently bound to the architectural index, and a ready flag taken from a per-physical-register scoreboard.

A destination is renamed through the allocate port. It pops the oldest entry of a FIFO free list, binds it to the architectural index, and returns both the new physical register and the mapping it displaced. The caller keeps that displaced mapping so that it can later undo the rename (through the restore port) or recycle the register (through the release port). Allocation clears the scoreboard bit of the new register, and a writeback port sets it again once the value exists.

The block exports the number of free physical registers. The stage uses this count to hold back an instruction whose destination count exceeds it. All results are registered and appear one clock after the request.

Top module: `regmap_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i and reads as ready; free_count equals PHYS_REGS-ARCH_REGS; allocations hand out ARCH_REGS, ARCH_REGS+1, ... in ascending order.
- R2: A lookup on either source port returns, one cycle later, the mapped physical register and the scoreboard bit of that register as it stood before the edge.
- R3: An allocate request with free_count nonzero gives, one cycle later, alloc_ok=1, alloc_new equal to the oldest free-list entry, and alloc_prev equal to the mapping that was replaced. The map now points to alloc_new, and free_count drops by one unless a release occurs in the same cycle.
- R4: A newly allocated physical register reads as not ready until it is written back.
- R5: A writeback of physical register p makes later lookups of p report ready.
- R6: An allocate request while free_count is 0 returns alloc_ok=0, leaves the map unchanged and leaves free_count at 0.
- R7: A restore writes restore_phys into the map entry restore_arch, and later lookups see it.
- R8: A release appends its register at the tail of the free list, so it is handed out after every register already queued. A release and an allocation in the same cycle leave free_count unchanged.
- R9: A lookup and an allocation of the same architectural register in the same cycle return the old mapping to the lookup.
- R10: A restore and an allocation of the same architectural register in the same cycle leave the map holding the restore value; the allocation still pops its register and reports it.
- R11: free_count never exceeds PHYS_REGS-ARCH_REGS; a release while the list is full, with no allocation in that cycle, is dropped.
- R12: An allocation and a writeback of the same physical register in the same cycle leave that register not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_a_arch | input | AW | Source port A architectural index |
| lk_b_arch | input | AW | Source port B architectural index |
| lk_a_phys | output | PW | Port A mapped physical register (registered) |
| lk_a_ready | output | 1 | Port A operand ready (registered) |
| lk_b_phys | output | PW | Port B mapped physical register (registered) |
| lk_b_ready | output | 1 | Port B operand ready (registered) |
| alloc_req | input | 1 | Request a new physical register for a destination |
| alloc_arch | input | AW | Destination architectural index |
| alloc_ok | output | 1 | Allocation granted in the previous cycle |
| alloc_new | output | PW | Newly bound physical register |
| alloc_prev | output | PW | Physical register displaced by the allocation |
| restore_en | input | 1 | Write one map entry directly |
| restore_arch | input | AW | Map entry to restore |
| restore_phys | input | PW | Value written into the map entry |
| release_en | input | 1 | Return a physical register to the free list |
| release_phys | input | PW | Register returned |
| wb_en | input | 1 | Mark a physical register ready |
| wb_phys | input | PW | Register written back |
| free_count | output | CW | Number of free physical registers |

## Verification
Three pairs of operations can meet in one cycle: a lookup and an allocation of the same architectural index, a restore and an allocation of the same index, and an allocation and a writeback that name the same physical register. The stimulus table issues the first and the third pair on purpose. The lookup result must show the pre-allocation mapping, and a lookup one cycle later must show the scoreboard bit still clear. A directed step drives the restore/allocate collision and then looks up the entry, which must hold the restore value while the allocation still reports the popped register.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  // index width for a set of n items, never below one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
  // width of a counter that must reach n inclusive
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rmap_table.sv
module rmap_table #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 48,
  localparam int AW = rmap_pkg::idx_bits(ARCH_REGS),
  localparam int PW = rmap_pkg::idx_bits(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [PW-1:0] rd_a_phys,
  output logic [PW-1:0] rd_b_phys,
  input  logic          al_en,
  input  logic [AW-1:0] al_arch,
  input  logic [PW-1:0] al_phys,
  output logic [PW-1:0] al_prev,
  input  logic          rs_en,
  input  logic [AW-1:0] rs_arch,
  input  logic [PW-1:0] rs_phys
);
  logic [PW-1:0] map_q [ARCH_REGS];

  // read-before-write: all reads see the contents before this edge
  assign rd_a_phys = map_q[rd_a_idx];
  assign rd_b_phys = map_q[rd_b_idx];
  assign al_prev   = map_q[al_arch];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else begin
      if (al_en) map_q[al_arch] <= al_phys;
      // restore is written last, so it wins on a shared entry
      if (rs_en) map_q[rs_arch] <= rs_phys;
    end
  end

  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (rst)
    rs_en |=> map_q[$past(rs_arch)] == $past(rs_phys)); // R10

  AST_ALLOC_BINDS: assert property (@(posedge clk) disable iff (rst)
    (al_en && !(rs_en && rs_arch == al_arch)) |=> map_q[$past(al_arch)] == $past(al_phys)); // R3
endmodule

// File: rtl/rmap_freelist.sv
module rmap_freelist #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 48,
  localparam int PW    = rmap_pkg::idx_bits(PHYS_REGS),
  localparam int DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int PTRW  = rmap_pkg::idx_bits(DEPTH),
  localparam int CW    = rmap_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_phys,
  output logic [PW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [PW-1:0]   mem_q [DEPTH];
  logic [PTRW-1:0] rd_q, wr_q;
  logic [CW-1:0]   cnt_q;
  logic            pop_ok, push_ok;

  function automatic logic [PTRW-1:0] step_ptr(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && ((cnt_q != CW'(DEPTH)) || pop_ok);
  assign head    = mem_q[rd_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PW'(ARCH_REGS + i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= push_phys;
        wr_q        <= step_ptr(wr_q);
      end
      if (pop_ok) rd_q <= step_ptr(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R11

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && cnt_q == CW'(DEPTH)) |=> cnt_q == CW'(DEPTH)); // R11

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q == '0) |=> cnt_q == '0); // R6

  AST_SWAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (pop && push && cnt_q != '0) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/rmap_scoreboard.sv
module rmap_scoreboard #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 48,
  localparam int PW = rmap_pkg::idx_bits(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] rd_a_idx,
  input  logic [PW-1:0] rd_b_idx,
  output logic          rd_a_ready,
  output logic          rd_b_ready,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_idx,
  input  logic          set_en,
  input  logic [PW-1:0] set_idx
);
  logic [PHYS_REGS-1:0] ready_q;

  assign rd_a_ready = ready_q[rd_a_idx];
  assign rd_b_ready = ready_q[rd_b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS_REGS; i++) ready_q[i] <= (i < ARCH_REGS);
    end else begin
      if (set_en) ready_q[set_idx] <= 1'b1;
      // clearing on allocation dominates a same-cycle writeback
      if (clr_en) ready_q[clr_idx] <= 1'b0;
    end
  end

  AST_CLR_DOMINATES: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !ready_q[$past(clr_idx)]); // R12

  AST_WB_SETS: assert property (@(posedge clk) disable iff (rst)
    (set_en && !(clr_en && clr_idx == set_idx)) |=> ready_q[$past(set_idx)]); // R5
endmodule

// File: rtl/regmap_rename.sv
module regmap_rename #(
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 48,
  localparam int AW = rmap_pkg::idx_bits(ARCH_REGS),
  localparam int PW = rmap_pkg::idx_bits(PHYS_REGS),
  localparam int CW = rmap_pkg::cnt_bits(PHYS_REGS - ARCH_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_a_arch,
  input  logic [AW-1:0] lk_b_arch,
  output logic [PW-1:0] lk_a_phys,
  output logic          lk_a_ready,
  output logic [PW-1:0] lk_b_phys,
  output logic          lk_b_ready,
  input  logic          alloc_req,
  input  logic [AW-1:0] alloc_arch,
  output logic          alloc_ok,
  output logic [PW-1:0] alloc_new,
  output logic [PW-1:0] alloc_prev,
  input  logic          restore_en,
  input  logic [AW-1:0] restore_arch,
  input  logic [PW-1:0] restore_phys,
  input  logic          release_en,
  input  logic [PW-1:0] release_phys,
  input  logic          wb_en,
  input  logic [PW-1:0] wb_phys,
  output logic [CW-1:0] free_count
);
  logic [PW-1:0] map_a, map_b, map_prev, fl_head;
  logic          rdy_a, rdy_b, fl_empty, grant;

  assign grant = alloc_req && !fl_empty;

  rmap_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_table (
    .clk(clk), .rst(rst),
    .rd_a_idx(lk_a_arch), .rd_b_idx(lk_b_arch),
    .rd_a_phys(map_a), .rd_b_phys(map_b),
    .al_en(grant), .al_arch(alloc_arch), .al_phys(fl_head), .al_prev(map_prev),
    .rs_en(restore_en), .rs_arch(restore_arch), .rs_phys(restore_phys)
  );

  rmap_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rst(rst),
    .pop(alloc_req), .push(release_en), .push_phys(release_phys),
    .head(fl_head), .empty(fl_empty), .count(free_count)
  );

  rmap_scoreboard #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_sb (
    .clk(clk), .rst(rst),
    .rd_a_idx(map_a), .rd_b_idx(map_b),
    .rd_a_ready(rdy_a), .rd_b_ready(rdy_b),
    .clr_en(grant), .clr_idx(fl_head),
    .set_en(wb_en), .set_idx(wb_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_a_phys  <= '0;
      lk_a_ready <= 1'b0;
      lk_b_phys  <= '0;
      lk_b_ready <= 1'b0;
      alloc_ok   <= 1'b0;
      alloc_new  <= '0;
      alloc_prev <= '0;
    end else begin
      lk_a_phys  <= map_a;
      lk_a_ready <= rdy_a;
      lk_b_phys  <= map_b;
      lk_b_ready <= rdy_b;
      alloc_ok   <= grant;
      alloc_new  <= fl_head;
      alloc_prev <= map_prev;
    end
  end

  AST_NO_GRANT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && free_count == '0) |=> !alloc_ok); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && free_count != '0 && !release_en) |=> free_count == $past(free_count) - 1'b1); // R3

  AST_OK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    alloc_ok |-> $past(alloc_req)); // R3
endmodule

// File: tb/sim_regmap_rename.sv
`timescale 1ns/1ps
module sim_regmap_rename;
  localparam int ARCH = 16;
  localparam int PHYS = 48;
  localparam int AW = 4;
  localparam int PW = 6;
  localparam int CW = 6;
  localparam int NV = 7;
  // vector: wb_en wb_phys alloc aarch sa sb | eok enew eprev epa era epb erb
  localparam logic [46:0] TBL [NV] = '{
    {1'b0, 6'd0,  1'b1, 4'd3, 4'd3, 4'd0, 1'b1, 6'd16, 6'd3,  6'd3,  1'b1, 6'd0,  1'b1},
    {1'b0, 6'd0,  1'b1, 4'd3, 4'd3, 4'd3, 1'b1, 6'd17, 6'd16, 6'd16, 1'b0, 6'd16, 1'b0},
    {1'b1, 6'd16, 1'b0, 4'd0, 4'd3, 4'd1, 1'b0, 6'd0,  6'd0,  6'd17, 1'b0, 6'd1,  1'b1},
    {1'b1, 6'd17, 1'b0, 4'd0, 4'd5, 4'd3, 1'b0, 6'd0,  6'd0,  6'd5,  1'b1, 6'd17, 1'b0},
    {1'b0, 6'd0,  1'b0, 4'd0, 4'd3, 4'd0, 1'b0, 6'd0,  6'd0,  6'd17, 1'b1, 6'd0,  1'b1},
    {1'b1, 6'd18, 1'b1, 4'd7, 4'd7, 4'd3, 1'b1, 6'd18, 6'd7,  6'd7,  1'b1, 6'd17, 1'b1},
    {1'b0, 6'd0,  1'b0, 4'd0, 4'd7, 4'd7, 1'b0, 6'd0,  6'd0,  6'd18, 1'b0, 6'd18, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] lk_a_arch, lk_b_arch, alloc_arch, restore_arch;
  logic [PW-1:0] lk_a_phys, lk_b_phys, alloc_new, alloc_prev, restore_phys, release_phys, wb_phys;
  logic lk_a_ready, lk_b_ready, alloc_req, alloc_ok, restore_en, release_en, wb_en;
  logic [CW-1:0] free_count;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  regmap_rename #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u0 (
    .clk(clk), .rst(rst),
    .lk_a_arch(lk_a_arch), .lk_b_arch(lk_b_arch),
    .lk_a_phys(lk_a_phys), .lk_a_ready(lk_a_ready),
    .lk_b_phys(lk_b_phys), .lk_b_ready(lk_b_ready),
    .alloc_req(alloc_req), .alloc_arch(alloc_arch),
    .alloc_ok(alloc_ok), .alloc_new(alloc_new), .alloc_prev(alloc_prev),
    .restore_en(restore_en), .restore_arch(restore_arch), .restore_phys(restore_phys),
    .release_en(release_en), .release_phys(release_phys),
    .wb_en(wb_en), .wb_phys(wb_phys), .free_count(free_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_a_arch = '0; lk_b_arch = '0; alloc_req = 0; alloc_arch = '0;
    restore_en = 0; restore_arch = '0; restore_phys = '0;
    release_en = 0; release_phys = '0; wb_en = 0; wb_phys = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    idle(); rst = 1; step(); step(); rst = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state of map, scoreboard and free list
    chk("R1 free_count", int'(free_count), PHYS - ARCH);
    for (int i = 0; i < ARCH; i += 2) begin
      lk_a_arch = AW'(i); lk_b_arch = AW'(i + 1); step();
      chk("R1 map a", int'(lk_a_phys), i);
      chk("R1 rdy a", int'(lk_a_ready), 1);
      chk("R1 map b", int'(lk_b_phys), i + 1);
      chk("R1 rdy b", int'(lk_b_ready), 1);
    end
    idle();

    // vector table: R2 R3 R4 R5 R9 R12
    for (int v = 0; v < NV; v++) begin
      wb_en = TBL[v][46]; wb_phys = TBL[v][45:40];
      alloc_req = TBL[v][39]; alloc_arch = TBL[v][38:35];
      lk_a_arch = TBL[v][34:31]; lk_b_arch = TBL[v][30:27];
      step();
      chk("R3 alloc_ok", int'(alloc_ok), int'(TBL[v][26]));
      if (TBL[v][26]) begin
        chk("R3 alloc_new", int'(alloc_new), int'(TBL[v][25:20]));
        chk("R3 R9 alloc_prev", int'(alloc_prev), int'(TBL[v][19:14]));
      end
      chk("R2 R9 lookup a", int'(lk_a_phys), int'(TBL[v][13:8]));
      chk("R4 R5 R12 ready a", int'(lk_a_ready), int'(TBL[v][7]));
      chk("R2 lookup b", int'(lk_b_phys), int'(TBL[v][6:1]));
      chk("R4 R5 ready b", int'(lk_b_ready), int'(TBL[v][0]));
    end
    idle();
    chk("R3 count after three allocs", int'(free_count), PHYS - ARCH - 3);

    // R8: release appends, count rises
    release_en = 1; release_phys = 6'd3; step(); idle();
    chk("R8 count after release", int'(free_count), 30);

    // R7: restore then look up
    restore_en = 1; restore_arch = 4'd3; restore_phys = 6'd3; step(); idle();
    lk_a_arch = 4'd3; step(); idle();
    chk("R7 restored entry", int'(lk_a_phys), 3);

    // R10: restore and allocate on same entry
    alloc_req = 1; alloc_arch = 4'd4; restore_en = 1; restore_arch = 4'd4; restore_phys = 6'd30;
    step(); idle();
    chk("R10 alloc_ok", int'(alloc_ok), 1);
    chk("R10 alloc_new", int'(alloc_new), 19);
    chk("R10 alloc_prev", int'(alloc_prev), 4);
    lk_a_arch = 4'd4; step(); idle();
    chk("R10 map holds restore", int'(lk_a_phys), 30);

    // R8: release and allocate together keep count
    alloc_req = 1; alloc_arch = 4'd5; release_en = 1; release_phys = 6'd16; step(); idle();
    chk("R8 swap alloc_new", int'(alloc_new), 20);
    chk("R8 swap count", int'(free_count), 29);

    // R8 R6: drain in FIFO order, then refuse
    for (int k = 0; k < 29; k++) begin
      alloc_req = 1; alloc_arch = 4'd6; step();
      chk("R8 drain order", int'(alloc_new), (k < 27) ? 21 + k : ((k == 27) ? 3 : 16));
    end
    chk("R6 count at empty", int'(free_count), 0);
    alloc_req = 1; alloc_arch = 4'd6; step(); idle();
    chk("R6 refused", int'(alloc_ok), 0);
    chk("R6 count stays", int'(free_count), 0);
    lk_a_arch = 4'd6; step(); idle();
    chk("R6 map unchanged", int'(lk_a_phys), 16);

    // R11: release while full is dropped
    do_reset();
    release_en = 1; release_phys = 6'd5; step(); idle();
    chk("R11 full release dropped", int'(free_count), PHYS - ARCH);
    alloc_req = 1; alloc_arch = 4'd1; step(); idle();
    chk("R1 R11 first alloc after reset", int'(alloc_new), ARCH);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule